// File: doc/BRIEF.md
# SPI Read-Only Memory Front End with Range Protection

This block lets an SPI host read a byte-addressed memory array. It works in SPI mode 0 and runs on a fast system clock. SCK, the active-low chip select and SI are passed through synchronizers, and the SCK edges are detected in the system clock domain. After chip select falls, the host sends an 8-bit instruction, most significant bit first. Two instructions are understood: one clears a write-enable flag, and the other starts a read.

A read instruction is followed by a 16-bit byte address. The block fetches bytes from the array through a simple combinational read port. It shifts each byte out on SO, most significant bit first, and the address advances after every byte for as long as the host keeps clocking. The address counter holds at the top address and does not wrap. Any byte past the top address, or inside a parameterized protected window, is replaced by 0xFF and marks the command as failed. The failure bit in the status is written when chip select rises.

Top module: `spi_rdmem_slave`

## Requirements
- R1: After reset, so_oe is 0, stat_wen equals WEN_INIT (default 1) and stat_err is 0.
- R2: SI is sampled on rising SCK edges and SO changes only on falling SCK edges. Both the instruction and the data are sent MSB first.
- R3: Instruction code 0x04 clears stat_wen. Because the command completes without error, stat_err reads 0 after chip select rises.
- R4: Instruction code 0x03 is followed by a 16-bit address, MSB first, in bit times 8 to 23. The MSB of the addressed byte is valid on SO, with so_oe at 1, from the falling edge that follows bit time 23. SI is ignored while data is shifted out.
- R5: During a read, the address increments after each byte, so continued clocking returns consecutive bytes.
- R6: The address counter never wraps past the top address (MEM_DEPTH-1, default 0xFF). mem_addr stays at the top address. Every byte the host clocks after the top byte reads 0xFF and causes an error.
- R7: A read whose start address is above the top address returns 0xFF for every byte and causes an error.
- R8: A byte whose address lies in the protected window PROT_BASE..PROT_LAST (default 0xC0..0xCF) reads as 0xFF and causes an error, even when the read started at an allowed address.
- R9: stat_err is written only when chip select rises, and only if a complete 8-bit instruction was received. It is set to 1 if an error occurred and to 0 otherwise. An error counts only if the host clocked at least one bit of the failing byte. A transaction shorter than 8 bits leaves the status unchanged.
- R10: An instruction code that is not recognized causes an error. The rest of that transaction is ignored, and so_oe stays 0.
- R11: so_oe is 0 whenever chip select is high, and during the instruction and address phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the SO pad driver |
| mem_addr | output | MAW (8) | Read address into the memory array |
| mem_rdata | input | 8 | Byte read from the array at mem_addr |
| stat_wen | output | 1 | Write-enable status flag |
| stat_err | output | 1 | Error status of the last completed command |

## Verification
Several rules are checked by assertions on every cycle. The shift register and the output enable may change only on permitted edges. The address counter either steps by one or holds at the top address. A guarded byte is always loaded as 0xFF. The write-enable flag drops after the clear instruction. The error status never changes while chip select is low. Only the bench scenarios can show which byte value reaches the pin at each bit time, and how errors collect across a whole transaction. They also cover the case where a read ends exactly on the top byte and records no error, and the case where an aborted or unrecognized transaction leaves or sets the status.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPC,
      PH_ADDR,
      PH_DATA,
      PH_SKIP
   } phase_e;

   localparam int OPC_W  = 8;
   localparam int BYTE_W = 8;

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
   parameter int            W       = 3,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   logic [STAGES-1:0][W-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("spi_rd_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_rd_guard.sv
module spi_rd_guard #(
   parameter int            AW        = 16,
   parameter logic [AW-1:0] TOP       = 16'h00FF,
   parameter bit            PROT_EN   = 1'b1,
   parameter logic [AW-1:0] PROT_BASE = 16'h00C0,
   parameter logic [AW-1:0] PROT_LAST = 16'h00CF
) (
   input  logic [AW-1:0] addr,
   input  logic          past_top,
   output logic          bad
);

   logic beyond;
   logic in_prot;

   assign beyond = addr > TOP;

   generate
      if (PROT_EN) begin : g_prot
         assign in_prot = (addr >= PROT_BASE) && (addr <= PROT_LAST);
      end else begin : g_noprot
         assign in_prot = 1'b0;
      end
   endgenerate

   assign bad = beyond | in_prot | past_top;

endmodule

// File: rtl/spi_rd_addrgen.sv
module spi_rd_addrgen #(
   parameter int            AW  = 16,
   parameter logic [AW-1:0] TOP = 16'h00FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          adv,
   output logic [AW-1:0] cur,
   output logic          past_top
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= '0;
         past_top <= 1'b0;
      end else if (ld) begin
         cur      <= ld_val;
         past_top <= 1'b0;
      end else if (adv) begin
         if (cur == TOP) begin
            past_top <= 1'b1;
         end else if (cur < TOP) begin
            cur <= cur + 1'b1;
         end
      end
   end

   // R5: each fetched byte below the top steps the address by one
   p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld && cur < TOP) |=> cur == $past(cur) + 1'b1);

   // R6: at the top the address holds and the overrun flag rises
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld && cur == TOP) |=> (cur == TOP && past_top));

   // R7: a start above the top never moves
   p_beyond_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld && cur > TOP) |=> $stable(cur));

endmodule

// File: rtl/spi_rdmem_slave.sv
module spi_rdmem_slave
   import spi_rd_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          MEM_DEPTH   = 256,
   parameter int          SYNC_STAGES = 2,
   parameter bit          PROT_EN     = 1'b1,
   parameter int          PROT_BASE   = 192,
   parameter int          PROT_LAST   = 207,
   parameter bit          WEN_INIT    = 1'b1,
   parameter logic [7:0]  OP_READ     = 8'h03,
   parameter logic [7:0]  OP_WRDI     = 8'h04,
   localparam int         MAW         = $clog2(MEM_DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sck,
   input  logic           cs_n,
   input  logic           si,
   output logic           so,
   output logic           so_oe,
   output logic [MAW-1:0] mem_addr,
   input  logic [7:0]     mem_rdata,
   output logic           stat_wen,
   output logic           stat_err
);

   localparam int            CNT_W  = $clog2(AW);
   localparam int            BCW    = $clog2(BYTE_W);
   localparam logic [AW-1:0] TOP_A  = AW'(MEM_DEPTH - 1);
   localparam logic [AW-1:0] PB_A   = AW'(PROT_BASE);
   localparam logic [AW-1:0] PL_A   = AW'(PROT_LAST);

   initial begin
      assert (AW > OPC_W) else $error("spi_rdmem_slave: AW too small");
      assert (MEM_DEPTH >= 2 && MEM_DEPTH <= 2 ** AW) else $error("spi_rdmem_slave: bad MEM_DEPTH");
      assert (PROT_LAST >= PROT_BASE) else $error("spi_rdmem_slave: empty protected window");
      assert (OP_READ != OP_WRDI) else $error("spi_rdmem_slave: opcodes collide");
   end

   // ---------------- pin synchronization and edge detection ----------------
   logic sck_s, cs_s, si_s, sck_q;
   logic sck_rise, sck_fall;

   spi_rd_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck, cs_n, si}),
      .q     ({sck_s, cs_s, si_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   assign sck_rise = sck_s & ~sck_q;
   assign sck_fall = ~sck_s & sck_q;

   // ---------------- state ----------------
   phase_e            phase;
   logic [CNT_W-1:0]  cnt_in;
   logic [AW-2:0]     in_sr;
   logic [BCW-1:0]    out_cnt;
   logic [7:0]        out_sr;
   logic              oe_r;
   logic              cur_bad;
   logic              err_acc;
   logic              cmd_seen;
   logic              wen_r;
   logic              err_r;

   logic [OPC_W-1:0]  opc_next;
   logic [AW-1:0]     addr_next;
   logic              opc_done, addr_done, load_byte;
   logic [AW-1:0]     cur_addr;
   logic              past_top, bad;

   assign opc_next  = {in_sr[OPC_W-2:0], si_s};
   assign addr_next = {in_sr, si_s};
   assign opc_done  = (phase == PH_OPC)  && sck_rise && (cnt_in == CNT_W'(OPC_W - 1));
   assign addr_done = (phase == PH_ADDR) && sck_rise && (cnt_in == CNT_W'(AW - 1));
   assign load_byte = (phase == PH_DATA) && sck_fall && (out_cnt == '0);

   // ---------------- address counter and range guard ----------------
   spi_rd_addrgen #(
      .AW  (AW),
      .TOP (TOP_A)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (addr_done),
      .ld_val   (addr_next),
      .adv      (load_byte),
      .cur      (cur_addr),
      .past_top (past_top)
   );

   spi_rd_guard #(
      .AW        (AW),
      .TOP       (TOP_A),
      .PROT_EN   (PROT_EN),
      .PROT_BASE (PB_A),
      .PROT_LAST (PL_A)
   ) u_guard (
      .addr     (cur_addr),
      .past_top (past_top),
      .bad      (bad)
   );

   assign mem_addr = cur_addr[MAW-1:0];

   // ---------------- transaction sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt_in   <= '0;
         in_sr    <= '0;
         out_cnt  <= '0;
         out_sr   <= '0;
         oe_r     <= 1'b0;
         cur_bad  <= 1'b0;
         err_acc  <= 1'b0;
         cmd_seen <= 1'b0;
         wen_r    <= WEN_INIT;
         err_r    <= 1'b0;
      end else if (cs_s) begin
         phase    <= PH_IDLE;
         oe_r     <= 1'b0;
         cmd_seen <= 1'b0;
         if (cmd_seen) err_r <= err_acc;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               phase   <= PH_OPC;
               cnt_in  <= '0;
               err_acc <= 1'b0;
               cur_bad <= 1'b0;
            end
            PH_OPC: begin
               if (sck_rise) begin
                  in_sr  <= {in_sr[AW-3:0], si_s};
                  cnt_in <= cnt_in + 1'b1;
                  if (opc_done) begin
                     cmd_seen <= 1'b1;
                     cnt_in   <= '0;
                     if (opc_next == OP_READ) begin
                        phase <= PH_ADDR;
                     end else if (opc_next == OP_WRDI) begin
                        wen_r <= 1'b0;
                        phase <= PH_SKIP;
                     end else begin
                        err_acc <= 1'b1;
                        phase   <= PH_SKIP;
                     end
                  end
               end
            end
            PH_ADDR: begin
               if (sck_rise) begin
                  in_sr  <= {in_sr[AW-3:0], si_s};
                  cnt_in <= cnt_in + 1'b1;
                  if (addr_done) begin
                     phase   <= PH_DATA;
                     out_cnt <= '0;
                  end
               end
            end
            PH_DATA: begin
               if (sck_fall) begin
                  out_cnt <= out_cnt + 1'b1;
                  if (out_cnt == '0) begin
                     out_sr  <= bad ? 8'hFF : mem_rdata;
                     cur_bad <= bad;
                     oe_r    <= 1'b1;
                  end else begin
                     out_sr <= {out_sr[6:0], 1'b0};
                  end
               end
               if (sck_rise && cur_bad) err_acc <= 1'b1;
            end
            PH_SKIP: begin
            end
            default: phase <= PH_SKIP;
         endcase
      end
   end

   assign so       = oe_r ? out_sr[7] : 1'b0;
   assign so_oe    = oe_r;
   assign stat_wen = wen_r;
   assign stat_err = err_r;

   // R11: the driver is released one cycle after chip select is seen high
   p_oe_off_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !so_oe);

   // R11: no drive during instruction and address bits
   p_oe_off_header_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OPC || phase == PH_ADDR) |-> !so_oe);

   // R2: the outgoing shift register moves only on a falling SCK edge
   p_shift_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(out_sr));

   // R8: a guarded address always loads the filler byte
   p_guard_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_byte && bad) |=> out_sr == 8'hFF);

   // R3: the disable instruction drops the write-enable flag
   p_wrdi_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (opc_done && !cs_s && opc_next == OP_WRDI) |=> !stat_wen);

   // R10: a skipped transaction never drives SO
   p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> !so_oe);

   // R9: status holds for the whole time chip select is low
   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> $stable(stat_err));

endmodule

// File: tb/tb_spi_rdmem_slave.sv
module tb_spi_rdmem_slave;

   localparam int HALF = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       cs_n = 1'b1;
   logic       si = 1'b0;
   logic       so, so_oe, stat_wen, stat_err;
   logic [7:0] mem_addr, mem_rdata;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   // bench memory model: byte value is a simple function of its address
   assign mem_rdata = 8'(mem_addr * 8'd37 + 8'd5);

   spi_rdmem_slave dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck       (sck),
      .cs_n      (cs_n),
      .si        (si),
      .so        (so),
      .so_oe     (so_oe),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .stat_wen  (stat_wen),
      .stat_err  (stat_err)
   );

   function automatic bit addr_bad(input int a);
      return (a > 255) || (a >= 192 && a <= 207);
   endfunction

   function automatic logic [7:0] exp_byte(input int a);
      return addr_bad(a) ? 8'hFF : 8'(a * 37 + 5);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic half_wait();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic xfer8(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_all, output logic oe_any);
      oe_all = 1'b1;
      oe_any = 1'b0;
      rx     = '0;
      for (int i = 7; i >= 0; i--) begin
         si = tx[i];
         half_wait();
         rx[i]  = so;
         oe_all = oe_all & so_oe;
         oe_any = oe_any | so_oe;
         sck = 1'b1;
         half_wait();
         sck = 1'b0;
      end
   endtask

   task automatic begin_txn();
      cs_n = 1'b0;
      half_wait();
   endtask

   task automatic end_txn();
      half_wait();
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic do_read(input int start, input int n, input string req);
      logic [7:0] rx;
      logic       oa, on;
      logic       exp_err;
      exp_err = 1'b0;
      begin_txn();
      xfer8(8'h03, rx, oa, on);
      chk("R11", "oe during instruction", on, 0);
      xfer8(8'(start >> 8), rx, oa, on);
      chk("R11", "oe during address high", on, 0);
      xfer8(8'(start), rx, oa, on);
      chk("R11", "oe during address low", on, 0);
      for (int i = 0; i < n; i++) begin
         // SI toggles during data; R4 says it is ignored
         xfer8(8'hA5 ^ 8'(i), rx, oa, on);
         chk(req, $sformatf("byte %0d of read at %0h", i, start), rx, exp_byte(start + i));
         chk("R4", "oe during data", oa, 1);
         if (start > 255 || addr_bad(start + i)) exp_err = 1'b1;
      end
      end_txn();
      chk("R11", "oe after deselect", so_oe, 0);
      chk("R9", $sformatf("error after read at %0h", start), stat_err, exp_err);
   endtask

   task automatic t_reset();
      chk("R1", "oe at reset", so_oe, 0);
      chk("R1", "wen at reset", stat_wen, 1);
      chk("R1", "err at reset", stat_err, 0);
   endtask

   task automatic t_single();   // R2 R4: single byte, MSB first
      do_read(16'h0010, 1, "R4");
   endtask

   task automatic t_stream();   // R5: consecutive bytes
      do_read(16'h0020, 5, "R5");
   endtask

   task automatic t_top();      // R6: no wrap, filler after top
      do_read(16'h00FF, 1, "R6");
      chk("R6", "top byte alone gives no error", stat_err, 0);
      do_read(16'h00FD, 5, "R6");
      chk("R6", "address holds at top", mem_addr, 8'hFF);
   endtask

   task automatic t_beyond();   // R7
      do_read(16'h1234, 2, "R7");
   endtask

   task automatic t_prot();     // R8: start allowed, run into window
      do_read(16'h00BE, 4, "R8");
      chk("R8", "error after entering window", stat_err, 1);
   endtask

   task automatic t_clean();    // R9: clean command clears error
      do_read(16'h0040, 2, "R9");
      chk("R9", "error cleared", stat_err, 0);
   endtask

   task automatic t_wrdi();     // R3
      logic [7:0] rx;
      logic       oa, on;
      do_read(16'h00C5, 1, "R8");
      chk("R8", "error set before clear instruction", stat_err, 1);
      begin_txn();
      xfer8(8'h04, rx, oa, on);
      end_txn();
      chk("R3", "wen cleared", stat_wen, 0);
      chk("R3", "err cleared by clean command", stat_err, 0);
   endtask

   task automatic t_unknown();  // R10
      logic [7:0] rx;
      logic       oa, on;
      begin_txn();
      xfer8(8'h5A, rx, oa, on);
      xfer8(8'h00, rx, oa, on);
      chk("R10", "no drive after unknown code", on, 0);
      xfer8(8'h10, rx, oa, on);
      chk("R10", "still no drive", on, 0);
      end_txn();
      chk("R10", "unknown code sets error", stat_err, 1);
   endtask

   task automatic t_short();    // R9: fewer than 8 bits leaves status
      begin_txn();
      for (int i = 0; i < 4; i++) begin
         si = 1'b0;
         half_wait();
         sck = 1'b1;
         half_wait();
         sck = 1'b0;
      end
      end_txn();
      chk("R9", "short transaction keeps error", stat_err, 1);
      chk("R9", "short transaction keeps wen", stat_wen, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_single();
      t_stream();
      t_top();
      t_beyond();
      t_prot();
      t_clean();
      t_wrdi();
      t_unknown();
      t_short();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule